// File: doc/BRIEF.md
# Mode-Configurable Convolution Chain

This block is one arithmetic lane of a small neural-network accelerator. Each input beat carries a square window of source samples from an upstream window loader, plus one addend sample. The kernel is held on a separate input for the whole job. A 4-bit mode word, latched when a job starts, selects any subset of four stages. The stages always run in the same order: kernel multiply-accumulate, addition of the addend, rectification (ReLU), and max pooling. One datapath therefore covers point products, convolution, matrix addition, activation and subsampling.

All data are signed 16-bit fixed point with 8 fractional bits. The multiply-accumulate runs in a 40-bit accumulator and saturates only when it is scaled back to 16 bits. A job is opened with a start pulse that latches the mode, the kernel width, the pool width and a result count. The chain then produces exactly that many results on a valid/ready output. It raises a one-cycle done pulse and goes idle.

Top module: `cchain_top`

## Requirements
- R1: After reset, out_valid_o, done_o and in_ready_o are all low.
- R2: With mode bit 0 set, the stage value is the sum of win*kern over rows and columns below the latched kernel width, arithmetically shifted right by 8 and saturated to 16 bits. Element (r,c) sits at bits [(r*KMAX+c)*16 +: 16] of win_i and kern_i.
- R3: With mode bit 0 clear, the stage value is window element (0,0), unchanged.
- R4: With mode bit 1 set, addend_i is added with saturation to [-32768, 32767].
- R5: With mode bit 2 set, a negative value becomes 0; a result emitted in that mode is never negative.
- R6: With mode bit 3 set, p*p consecutive stage values are reduced to their maximum, which becomes one result. p is the latched pool width: 0 counts as 1 and values above 8 count as 8. With bit 3 clear, each input yields one result.
- R7: The stages compose in the fixed order pool(relu(conv + addend)).
- R8: A job emits exactly count_i results. in_ready_o is low when idle, and it is low once enough inputs for count_i results have been taken.
- R9: done_o pulses for one cycle, in the cycle after the last result handshake. A start with count 0 gives a done pulse in the cycle after the start and emits no results.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value.
- R11: The configuration is latched at an accepted start. A start pulse while a job is running is ignored, and the running job keeps its configuration.
- R12: Kernel width 0 gives a convolution value of 0. Kernel widths above KMAX are clamped to KMAX. A convolution sum beyond the 16-bit range saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a job when idle; latches the configuration |
| mode_i | input | 4 | Stage enables: bit0 conv, bit1 add, bit2 ReLU, bit3 pool |
| kw_i | input | KW_W (3) | Kernel width |
| pool_w_i | input | PW_W (4) | Pool width |
| count_i | input | CNT_W (16) | Number of results in the job |
| kern_i | input | KMAX*KMAX*DW (400) | Kernel values, held for the job |
| in_valid_i | input | 1 | Window beat valid |
| in_ready_o | output | 1 | Window beat accepted |
| win_i | input | KMAX*KMAX*DW (400) | Window samples |
| addend_i | input | DW (16) | Addend sample for the beat |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result taken |
| out_data_o | output | DW (16) | Result value |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The hardest case to reach from the ports is the job boundary under back-pressure. The chain must have stopped taking window beats exactly when its issued results reach the count. It must still hold a stalled result, and it must raise done only after that result drains. The bench reaches this by holding in_valid_i high for several cycles past the needed number of beats, while out_ready_i toggles pseudo-randomly. It also pulses start mid-job with a different configuration, so that a wrong latch shows up in the result values.

// File: rtl/cchain_pkg.sv
package cchain_pkg;
    // Stage-enable positions inside the mode word; the order is the pipeline order.
    localparam int MODE_W    = 4;
    localparam int BIT_CONV  = 0;
    localparam int BIT_ADD   = 1;
    localparam int BIT_RELU  = 2;
    localparam int BIT_POOL  = 3;

    typedef logic [MODE_W-1:0] mode_t;
endpackage

// File: rtl/chain_mac.sv
// Window multiply-accumulate with kernel-width masking, or element (0,0) bypass.
module chain_mac #(
    parameter int DW    = 16,
    parameter int FRAC  = 8,
    parameter int ACC_W = 40,
    parameter int KMAX  = 5,
    localparam int NEL  = KMAX * KMAX,
    localparam int KW_W = $clog2(KMAX + 1)
) (
    input  logic [NEL*DW-1:0] win_i,
    input  logic [NEL*DW-1:0] kern_i,
    input  logic [KW_W-1:0]   kw_i,
    input  logic              en_i,
    output logic [DW-1:0]     y_o
);
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SMIN = -SMAX - 1;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;
    logic signed [2*DW-1:0]  prod;

    always_comb begin
        acc  = '0;
        prod = '0;
        for (int r = 0; r < KMAX; r++) begin
            for (int c = 0; c < KMAX; c++) begin
                prod = $signed(win_i[(r*KMAX+c)*DW +: DW]) * $signed(kern_i[(r*KMAX+c)*DW +: DW]);
                if ((KW_W'(r) < kw_i) && (KW_W'(c) < kw_i)) begin
                    acc = acc + ACC_W'(prod);
                end
            end
        end
        scaled = acc >>> FRAC;
        if (!en_i) begin
            y_o = win_i[DW-1:0];
        end else if (scaled > SMAX) begin
            y_o = SMAX[DW-1:0];
        end else if (scaled < SMIN) begin
            y_o = SMIN[DW-1:0];
        end else begin
            y_o = scaled[DW-1:0];
        end
    end
endmodule

// File: rtl/chain_post.sv
// Saturating addend stage followed by rectification.
module chain_post #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] addend_i,
    input  logic          add_en_i,
    input  logic          relu_en_i,
    output logic [DW-1:0] y_o
);
    logic signed [DW:0]   sum;
    logic        [DW-1:0] added;

    always_comb begin
        sum = $signed({x_i[DW-1], x_i}) + $signed({addend_i[DW-1], addend_i});
        if (!add_en_i) begin
            added = x_i;
        end else if (sum[DW] != sum[DW-1]) begin
            added = sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end else begin
            added = sum[DW-1:0];
        end
        y_o = (relu_en_i && added[DW-1]) ? '0 : added;
    end
endmodule

// File: rtl/chain_pool.sv
// Running-max reduction over a tile of consecutive values.
module chain_pool #(
    parameter int DW     = 16,
    parameter int AREA_W = 7
) (
    input  logic [DW-1:0]     x_i,
    input  logic              en_i,
    input  logic [AREA_W-1:0] cnt_i,
    input  logic [AREA_W-1:0] area_i,
    input  logic [DW-1:0]     max_i,
    output logic [DW-1:0]     max_o,
    output logic [AREA_W-1:0] cnt_o,
    output logic              emit_o
);
    always_comb begin
        if ((cnt_i == '0) || ($signed(x_i) > $signed(max_i))) begin
            max_o = x_i;
        end else begin
            max_o = max_i;
        end
        emit_o = !en_i || (cnt_i == area_i - AREA_W'(1));
        cnt_o  = emit_o ? '0 : cnt_i + AREA_W'(1);
    end
endmodule

// File: rtl/cchain_top.sv
module cchain_top
    import cchain_pkg::*;
#(
    parameter int DW       = 16,
    parameter int FRAC     = 8,
    parameter int ACC_W    = 40,
    parameter int KMAX     = 5,
    parameter int POOL_MAX = 8,
    parameter int CNT_W    = 16,
    localparam int NEL     = KMAX * KMAX,
    localparam int KW_W    = $clog2(KMAX + 1),
    localparam int PW_W    = $clog2(POOL_MAX + 1),
    localparam int AREA_W  = $clog2(POOL_MAX * POOL_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [KW_W-1:0]   kw_i,
    input  logic [PW_W-1:0]   pool_w_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [NEL*DW-1:0] kern_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [NEL*DW-1:0] win_i,
    input  logic [DW-1:0]     addend_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DW-1:0]     out_data_o,
    output logic              done_o
);
    typedef struct packed {
        logic              busy;
        mode_t             mode;
        logic [KW_W-1:0]   kw;
        logic [AREA_W-1:0] area;
        logic [CNT_W-1:0]  limit;
        logic [CNT_W-1:0]  issued;
        logic [CNT_W-1:0]  emitted;
        logic [AREA_W-1:0] pcnt;
        logic [DW-1:0]     pmax;
        logic              ovalid;
        logic [DW-1:0]     odata;
        logic              done;
    } state_t;

    state_t state_d, state_q;

    logic [DW-1:0]     mac_y, post_y, pool_max;
    logic [AREA_W-1:0] pool_cnt;
    logic              pool_emit;
    logic              in_fire, out_fire;
    logic [PW_W-1:0]   pw_eff;
    logic [AREA_W-1:0] pw_ext;

    chain_mac #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W), .KMAX(KMAX)) mac_i (
        .win_i (win_i),
        .kern_i(kern_i),
        .kw_i  (state_q.kw),
        .en_i  (state_q.mode[BIT_CONV]),
        .y_o   (mac_y)
    );

    chain_post #(.DW(DW)) post_i (
        .x_i      (mac_y),
        .addend_i (addend_i),
        .add_en_i (state_q.mode[BIT_ADD]),
        .relu_en_i(state_q.mode[BIT_RELU]),
        .y_o      (post_y)
    );

    chain_pool #(.DW(DW), .AREA_W(AREA_W)) pool_i (
        .x_i   (post_y),
        .en_i  (state_q.mode[BIT_POOL]),
        .cnt_i (state_q.pcnt),
        .area_i(state_q.area),
        .max_i (state_q.pmax),
        .max_o (pool_max),
        .cnt_o (pool_cnt),
        .emit_o(pool_emit)
    );

    always_comb begin
        state_d       = state_q;
        state_d.done  = 1'b0;

        if (pool_w_i == '0) begin
            pw_eff = PW_W'(1);
        end else if (pool_w_i > PW_W'(POOL_MAX)) begin
            pw_eff = PW_W'(POOL_MAX);
        end else begin
            pw_eff = pool_w_i;
        end
        pw_ext = AREA_W'(pw_eff);

        out_fire   = state_q.ovalid && out_ready_i;
        in_ready_o = state_q.busy && (state_q.issued != state_q.limit)
                     && (!state_q.ovalid || out_ready_i);
        in_fire    = in_valid_i && in_ready_o;

        if (out_fire) begin
            state_d.ovalid  = 1'b0;
            state_d.emitted = state_q.emitted + CNT_W'(1);
            if (state_q.emitted + CNT_W'(1) == state_q.limit) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end
        end

        if (in_fire) begin
            state_d.pcnt = pool_cnt;
            state_d.pmax = pool_max;
            if (pool_emit) begin
                state_d.ovalid = 1'b1;
                state_d.odata  = pool_max;
                state_d.issued = state_q.issued + CNT_W'(1);
            end
        end

        if (start_i && !state_q.busy) begin
            state_d.mode    = mode_i;
            state_d.kw      = (kw_i > KW_W'(KMAX)) ? KW_W'(KMAX) : kw_i;
            state_d.area    = pw_ext * pw_ext;
            state_d.limit   = count_i;
            state_d.issued  = '0;
            state_d.emitted = '0;
            state_d.pcnt    = '0;
            state_d.ovalid  = 1'b0;
            state_d.busy    = (count_i != '0);
            state_d.done    = (count_i == '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid_o = state_q.ovalid;
    assign out_data_o  = state_q.odata;
    assign done_o      = state_q.done;

    // Internal views for the bound checker.
    logic             busy_w, relu_en_w;
    logic [CNT_W-1:0] emitted_w, limit_w;
    assign busy_w    = state_q.busy;
    assign relu_en_w = state_q.mode[BIT_RELU];
    assign emitted_w = state_q.emitted;
    assign limit_w   = state_q.limit;
endmodule

// File: rtl/cchain_chk.sv
module cchain_chk #(
    parameter int DW    = 16,
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             out_valid_i,
    input logic             out_ready_i,
    input logic [DW-1:0]    out_data_i,
    input logic             in_ready_i,
    input logic             done_i,
    input logic             busy_i,
    input logic             relu_en_i,
    input logic [CNT_W-1:0] emitted_i,
    input logic [CNT_W-1:0] limit_i
);
    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_data_i)));

    assert_relu_nonneg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_i && relu_en_i) |-> !out_data_i[DW-1]);

    assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !busy_i);

    assert_ready_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ready_i |-> busy_i);

    assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> (emitted_i < limit_i));

    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !$past(done_i)) |-> !out_valid_i);
endmodule

bind cchain_top cchain_chk #(.DW(DW), .CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .out_valid_i(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_i (out_data_o),
    .in_ready_i (in_ready_o),
    .done_i     (done_o),
    .busy_i     (busy_w),
    .relu_en_i  (relu_en_w),
    .emitted_i  (emitted_w),
    .limit_i    (limit_w)
);

// File: tb/cchain_top_tb_top.sv
module cchain_top_tb_top;
    localparam int DW = 16, KMAX = 5, NEL = KMAX * KMAX;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [3:0]        mode_i = '0;
    logic [2:0]        kw_i = '0;
    logic [3:0]        pool_w_i = '0;
    logic [15:0]       count_i = '0;
    logic [NEL*DW-1:0] kern_i = '0;
    logic              in_valid_i = 1'b0;
    logic              in_ready_o;
    logic [NEL*DW-1:0] win_i = '0;
    logic [DW-1:0]     addend_i = '0;
    logic              out_valid_o;
    logic              out_ready_i = 1'b1;
    logic [DW-1:0]     out_data_o;
    logic              done_o;

    cchain_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
        .kw_i(kw_i), .pool_w_i(pool_w_i), .count_i(count_i), .kern_i(kern_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .win_i(win_i),
        .addend_i(addend_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_data_o(out_data_o), .done_o(done_o)
    );

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R2";
    bit ready_rand = 1'b0;

    // Behavioural model state
    bit   mbusy = 0, exp_done = 0, prev_hold = 0;
    bit [3:0] mmode;
    int   mkw, marea, mlimit, missued, memitted, mpcnt, mpmax;
    int   expq[$];
    logic [DW-1:0] prev_data;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int stage_val(input logic [NEL*DW-1:0] w, input logic [NEL*DW-1:0] k,
                                     input logic [DW-1:0] a);
        longint acc = 0;
        int v;
        logic signed [DW-1:0] e, kk;
        if (mmode[0]) begin
            for (int r = 0; r < mkw; r++)
                for (int c = 0; c < mkw; c++) begin
                    e  = w[(r*KMAX+c)*DW +: DW];
                    kk = k[(r*KMAX+c)*DW +: DW];
                    acc += longint'(e) * longint'(kk);
                end
            v = sat16(acc >>> 8);
        end else begin
            e = w[DW-1:0];
            v = int'(e);
        end
        if (mmode[1]) begin
            e = a;
            v = sat16(longint'(v) + longint'(e));
        end
        if (mmode[2] && v < 0) v = 0;
        return v;
    endfunction

    always @(negedge clk) begin
        bit busy_pre;
        bit exp_rdy;
        int v;
        if (rst_n) begin
            busy_pre = mbusy;
            check(done_o == exp_done, "R9 done timing", done_o, exp_done);
            exp_done = 0;
            exp_rdy = mbusy && (missued < mlimit) && (!out_valid_o || out_ready_i);
            check(in_ready_o == exp_rdy, "R8 in_ready", in_ready_o, exp_rdy);
            if (prev_hold)
                check(out_valid_o && out_data_o == prev_data, "R10 hold", out_data_o, prev_data);
            prev_hold = out_valid_o && !out_ready_i;
            prev_data = out_data_o;
            if (out_valid_o && out_ready_i) begin
                if (expq.size() == 0) begin
                    check(0, {cur_req, " unexpected result"}, out_data_o, 0);
                end else begin
                    v = expq.pop_front();
                    check(out_data_o == DW'(v), {cur_req, " result"}, int'($signed(out_data_o)), v);
                end
                memitted++;
                if (memitted == mlimit) begin
                    mbusy = 0;
                    exp_done = 1;
                end
            end
            if (in_valid_i && in_ready_o) begin
                v = stage_val(win_i, kern_i, addend_i);
                if (mmode[3]) begin
                    if (mpcnt == 0 || v > mpmax) mpmax = v;
                    if (mpcnt == marea - 1) begin
                        expq.push_back(mpmax);
                        missued++;
                        mpcnt = 0;
                    end else mpcnt++;
                end else begin
                    expq.push_back(v);
                    missued++;
                end
            end
            if (start_i && !busy_pre) begin
                int pw;
                mmode = mode_i;
                mkw = (kw_i > KMAX) ? KMAX : int'(kw_i);
                pw = (pool_w_i == 0) ? 1 : ((pool_w_i > 8) ? 8 : int'(pool_w_i));
                marea = pw * pw;
                mlimit = int'(count_i);
                missued = 0; memitted = 0; mpcnt = 0;
                expq.delete();
                if (mlimit == 0) exp_done = 1;
                else mbusy = 1;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        out_ready_i = ready_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic fill_vec(output logic [NEL*DW-1:0] v, input int range);
        for (int i = 0; i < NEL; i++)
            v[i*DW +: DW] = DW'(int'($urandom_range(0, 2*range - 1)) - range);
    endtask

    task automatic start_job(input logic [3:0] m, input int kw, input int pw, input int lim,
                             input int krange, input string req);
        @(posedge clk); #1;
        cur_req = req;
        fill_vec(kern_i, krange);
        mode_i = m; kw_i = 3'(kw); pool_w_i = 4'(pw); count_i = 16'(lim);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic feed(input int n, input int range);
        for (int i = 0; i < n; i++) begin
            in_valid_i = 1'b1;
            fill_vec(win_i, range);
            addend_i = DW'(int'($urandom_range(0, 2*range - 1)) - range);
            forever begin
                @(negedge clk);
                if (in_ready_o) break;
            end
            @(posedge clk); #1;
        end
        // R8: surplus beats must be refused
        repeat (4) begin
            fill_vec(win_i, range);
            @(posedge clk); #1;
        end
        in_valid_i = 1'b0;
        while (mbusy) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic run(input logic [3:0] m, input int kw, input int pw, input int lim,
                       input int range, input string req);
        int per;
        per = m[3] ? ((pw == 0) ? 1 : pw * pw) : 1;
        start_job(m, kw, pw, lim, range, req);
        feed(lim * per, range);
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid_o && !done_o && !in_ready_o, "R1 reset", {out_valid_o, done_o, in_ready_o}, 0);

        run(4'b0001, 3, 1, 6, 300, "R2 conv");
        ready_rand = 1'b1;
        run(4'b0001, 5, 1, 6, 400, "R2 conv kw5 backpressure");
        run(4'b0000, 2, 1, 5, 1000, "R3 bypass");
        run(4'b0010, 0, 1, 8, 32768, "R4 add sat");
        run(4'b0100, 0, 1, 8, 2000, "R5 relu");
        run(4'b1000, 0, 2, 3, 2000, "R6 pool p2");
        run(4'b1000, 0, 3, 2, 2000, "R6 pool p3");
        run(4'b1000, 0, 0, 3, 2000, "R6 pool p0");
        run(4'b1111, 3, 2, 4, 200, "R7 full");
        run(4'b0111, 4, 1, 5, 300, "R7 conv add relu");
        run(4'b0001, 0, 1, 3, 1000, "R12 kw0");
        run(4'b0001, 7, 1, 3, 300, "R12 kw clamp");
        run(4'b0001, 5, 1, 6, 32768, "R12 conv sat");
        run(4'b0000, 0, 1, 0, 10, "R9 zero count");

        // R11: start during a running job is ignored
        start_job(4'b0001, 3, 1, 4, 300, "R11 start ignored");
        fork
            feed(4, 300);
            begin
                repeat (3) @(posedge clk);
                #2;
                mode_i = 4'b1110; count_i = 16'd1; kw_i = 3'd1;
                start_i = 1'b1;
                @(posedge clk); #2;
                start_i = 1'b0;
            end
        join
        check(expq.size() == 0, "R11 queue drained", expq.size(), 0);
        check(!mbusy, "R8 idle after job", mbusy, 0);

        repeat (5) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule